// File: doc/BRIEF.md
# Floppy Controller Rate-Control Register

This block is the write-only rate-control register of a floppy disk controller. A host write carries a two-bit data-rate code, a three-bit write-precompensation code, a manual low-power request and a self-clearing software-reset bit. A second writer, the configuration control register, also drives the data-rate field. The active rate is whichever of the two writes came last.

The block turns the precompensation code into a delay, counted in steps of 41.67 ns, for the write-data delay line. Code 000 picks a default that depends on the active rate. An enable is raised once the current track reaches a programmable start track. A low-power flag gates the controller clock and the data separator. The flag is set by a write and cleared by a software reset or by a host read of the data or main status register.

Two small state machines sit inside. The power machine has states ST_AWAKE and ST_DOZE. It takes transition T_SLEEP (ST_AWAKE to ST_DOZE on a write with bit 6 set and no wake event) and T_WAKE (ST_DOZE to ST_AWAKE on any wake event). The reset-pulse machine has states ST_IDLE and ST_PULSE. It takes transition T_FIRE (ST_IDLE to ST_PULSE on a write with bit 7 set), T_REFIRE (ST_PULSE stays in ST_PULSE on another such write) and T_DONE (ST_PULSE to ST_IDLE otherwise).

Top module: `fdc_rate_ctrl`

## Requirements
- R1: After hardware reset (rst_n low), the rate code is 2'b10 (250 kb/s), the precompensation code is 000, low_power is 0 and sw_rst_pulse is 0.
- R2: A write (wr_en high) loads the rate from wr_data[1:0] and the precompensation code from wr_data[4:2]. The new values appear on the outputs in the cycle after the write.
- R3: A write on ccr_wr_en loads ccr_rate into the rate code and leaves the precompensation code unchanged. The rate follows the most recent of the two writers. If both write in the same cycle, ccr_rate is taken.
- R4: Precompensation codes 001 to 110 give precomp_steps equal to the code (1 to 6). Code 111 gives 0 (disabled).
- R5: Precompensation code 000 gives precomp_steps of 3 for rate codes 00, 01 and 10, and 1 for rate code 11.
- R6: A write with wr_data[7]=1 raises sw_rst_pulse for exactly the one cycle after the write, unless the next cycle carries another such write.
- R7: A software reset (sw_rst_in or sw_rst_pulse) does not change the rate code or the precompensation code.
- R8: A write with wr_data[6]=1 sets low_power in the next cycle. While low_power is set, writes with wr_data[6]=0 do not clear it.
- R9: While low_power is set, data_rd, status_rd, sw_rst_in or sw_rst_pulse clears it in the next cycle. A wake event in the same cycle as an entering write leaves low_power at 0.
- R10: precomp_en is 1 exactly when track >= start_track and precomp_steps is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Hardware reset, active low |
| wr_en | input | 1 | Host write strobe for this register |
| wr_data | input | 8 | Host write data |
| ccr_wr_en | input | 1 | Configuration control register write strobe |
| ccr_rate | input | 2 | Rate field from the configuration control register |
| data_rd | input | 1 | Host access to the data register |
| status_rd | input | 1 | Host access to the main status register |
| sw_rst_in | input | 1 | Software reset from the digital output register |
| track | input | 8 | Current track number |
| start_track | input | 8 | Track at which precompensation starts |
| rate_code | output | 2 | Active data-rate code |
| precomp_steps | output | 3 | Resolved delay in 41.67 ns steps |
| precomp_en | output | 1 | Precompensation enable |
| low_power | output | 1 | Manual low-power flag |
| sw_rst_pulse | output | 1 | One-cycle software-reset pulse |

## Verification
Entering low power and waking from it can fall in the same cycle, and this is where the block is most likely to go wrong. The bench provokes the case in two ways. First, it asserts data_rd in the same cycle as a write with bit 6 set, and expects low_power to stay 0 afterwards. Second, it writes bits 6 and 7 together. The flag must then rise for one cycle and fall in the following cycle, when the block's own reset pulse wakes it. The two register writers colliding in one cycle are judged the same way: the bench expects the rate from the configuration port.

// File: rtl/fdc_rate_pkg.sv
package fdc_rate_pkg;
    typedef enum logic {ST_AWAKE = 1'b0, ST_DOZE = 1'b1} pwr_state_t;
    typedef enum logic {ST_IDLE = 1'b0, ST_PULSE = 1'b1} rst_state_t;

    localparam int RATE_W = 2;
    localparam int PC_W   = 3;
    localparam logic [RATE_W-1:0] RATE_250K = 2'b10;
    localparam logic [RATE_W-1:0] RATE_1M   = 2'b11;
    localparam logic [PC_W-1:0]   PC_DEFAULT = 3'b000;
    localparam logic [PC_W-1:0]   PC_OFF     = 3'b111;
endpackage

// File: rtl/fdc_rate_regs.sv
module fdc_rate_regs
    import fdc_rate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [RATE_W-1:0] wr_rate,
    input  logic [PC_W-1:0]   wr_pc,
    input  logic              ccr_wr_en,
    input  logic [RATE_W-1:0] ccr_rate,
    output logic [RATE_W-1:0] rate_q,
    output logic [PC_W-1:0]   pc_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rate_q <= RATE_250K;
            pc_q   <= PC_DEFAULT;
        end else begin
            if (ccr_wr_en)  rate_q <= ccr_rate;
            else if (wr_en) rate_q <= wr_rate;
            if (wr_en)      pc_q   <= wr_pc;
        end
    end

    // R3
    ccr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ccr_wr_en |=> (rate_q == $past(ccr_rate)));

    // R7
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(pc_q));
endmodule

// File: rtl/fdc_rst_pulse.sv
module fdc_rst_pulse
    import fdc_rate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic pulse
);
    rst_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (fire) state_d = ST_PULSE;
            ST_PULSE: state_d = fire ? ST_PULSE : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb pulse = (state_q == ST_PULSE);

    // R6
    pulse_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> pulse);

    // R6
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && !fire) |=> !pulse);
endmodule

// File: rtl/fdc_power_fsm.sv
module fdc_power_fsm
    import fdc_rate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enter,
    input  logic wake,
    output logic low_power
);
    pwr_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_AWAKE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_AWAKE: if (enter && !wake) state_d = ST_DOZE;
            ST_DOZE:  if (wake)           state_d = ST_AWAKE;
            default:  state_d = ST_AWAKE;
        endcase
    end

    always_comb low_power = (state_q == ST_DOZE);

    // R9
    wake_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> !low_power);

    // R8
    doze_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (low_power && !wake) |=> low_power);

    // R8
    doze_enters_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enter && !wake) |=> low_power);
endmodule

// File: rtl/fdc_precomp.sv
module fdc_precomp
    import fdc_rate_pkg::*;
#(
    parameter int TRACK_W   = 8,
    parameter int STEP_W    = 3,
    parameter int DEF_SLOW  = 3,
    parameter int DEF_FAST  = 1
) (
    input  logic [RATE_W-1:0]  rate,
    input  logic [PC_W-1:0]    pc_code,
    input  logic [TRACK_W-1:0] track,
    input  logic [TRACK_W-1:0] start_track,
    output logic [STEP_W-1:0]  steps,
    output logic               enable
);
    localparam logic [STEP_W-1:0] SLOW_STEPS = STEP_W'(DEF_SLOW);
    localparam logic [STEP_W-1:0] FAST_STEPS = STEP_W'(DEF_FAST);

    always_comb begin
        if (pc_code == PC_DEFAULT)
            steps = (rate == RATE_1M) ? FAST_STEPS : SLOW_STEPS;
        else if (pc_code == PC_OFF)
            steps = '0;
        else
            steps = STEP_W'(pc_code);
    end

    always_comb enable = (track >= start_track) && (steps != '0);

    // R4
    steps_range_chk: assert final (steps <= STEP_W'(6));
endmodule

// File: rtl/fdc_rate_ctrl.sv
module fdc_rate_ctrl
    import fdc_rate_pkg::*;
#(
    parameter int TRACK_W  = 8,
    parameter int STEP_W   = 3,
    parameter int DEF_SLOW = 3,
    parameter int DEF_FAST = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [7:0]         wr_data,
    input  logic               ccr_wr_en,
    input  logic [1:0]         ccr_rate,
    input  logic               data_rd,
    input  logic               status_rd,
    input  logic               sw_rst_in,
    input  logic [TRACK_W-1:0] track,
    input  logic [TRACK_W-1:0] start_track,
    output logic [1:0]         rate_code,
    output logic [STEP_W-1:0]  precomp_steps,
    output logic               precomp_en,
    output logic               low_power,
    output logic               sw_rst_pulse
);
    localparam int BIT_SLEEP = 6;
    localparam int BIT_SRST  = 7;

    logic [PC_W-1:0] pc_code;
    logic            wake;
    logic            unused_rsvd;

    assign unused_rsvd = wr_data[5];
    assign wake = data_rd | status_rd | sw_rst_in | sw_rst_pulse;

    fdc_rate_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_rate   (wr_data[1:0]),
        .wr_pc     (wr_data[4:2]),
        .ccr_wr_en (ccr_wr_en),
        .ccr_rate  (ccr_rate),
        .rate_q    (rate_code),
        .pc_q      (pc_code)
    );

    fdc_rst_pulse u_rst (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (wr_en & wr_data[BIT_SRST]),
        .pulse (sw_rst_pulse)
    );

    fdc_power_fsm u_pwr (
        .clk       (clk),
        .rst_n     (rst_n),
        .enter     (wr_en & wr_data[BIT_SLEEP]),
        .wake      (wake),
        .low_power (low_power)
    );

    fdc_precomp #(
        .TRACK_W  (TRACK_W),
        .STEP_W   (STEP_W),
        .DEF_SLOW (DEF_SLOW),
        .DEF_FAST (DEF_FAST)
    ) u_pc (
        .rate        (rate_code),
        .pc_code     (pc_code),
        .track       (track),
        .start_track (start_track),
        .steps       (precomp_steps),
        .enable      (precomp_en)
    );

    // R10
    en_needs_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        precomp_en |-> (precomp_steps != '0));

    // R7
    swrst_keeps_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !ccr_wr_en) |=> $stable(rate_code));
endmodule

// File: tb/fdc_rate_ctrl_tb.sv
module fdc_rate_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       ccr_wr_en = 1'b0;
    logic [1:0] ccr_rate = '0;
    logic       data_rd = 1'b0;
    logic       status_rd = 1'b0;
    logic       sw_rst_in = 1'b0;
    logic [7:0] track = '0;
    logic [7:0] start_track = '0;
    logic [1:0] rate_code;
    logic [2:0] precomp_steps;
    logic       precomp_en;
    logic       low_power;
    logic       sw_rst_pulse;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    fdc_rate_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .ccr_wr_en(ccr_wr_en), .ccr_rate(ccr_rate), .data_rd(data_rd),
        .status_rd(status_rd), .sw_rst_in(sw_rst_in), .track(track),
        .start_track(start_track), .rate_code(rate_code),
        .precomp_steps(precomp_steps), .precomp_en(precomp_en),
        .low_power(low_power), .sw_rst_pulse(sw_rst_pulse)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        check(act == exp, req, act, exp);
    endtask

    // Drives one write at a negedge; returns at the next negedge.
    task automatic host_write(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic t_reset;
        chk_eq("R1 rate", rate_code, 2);
        chk_eq("R1 steps", precomp_steps, 3);
        chk_eq("R1 low_power", low_power, 0);
        chk_eq("R1 pulse", sw_rst_pulse, 0);
    endtask

    task automatic t_write_fields;
        host_write({3'b000, 3'b101, 2'b01});
        chk_eq("R2 rate", rate_code, 1);
        chk_eq("R2 steps", precomp_steps, 5);
        for (int c = 1; c <= 7; c++) begin
            host_write({3'b000, 3'(c), 2'b00});
            chk_eq("R4 steps", precomp_steps, (c == 7) ? 0 : c);
        end
    endtask

    task automatic t_default;
        for (int r = 0; r < 4; r++) begin
            host_write({3'b000, 3'b000, 2'(r)});
            chk_eq("R5 default", precomp_steps, (r == 3) ? 1 : 3);
        end
    endtask

    task automatic t_ccr;
        host_write({3'b000, 3'b010, 2'b00});
        @(negedge clk);
        ccr_wr_en = 1'b1; ccr_rate = 2'b11;
        @(negedge clk);
        ccr_wr_en = 1'b0;
        chk_eq("R3 ccr rate", rate_code, 3);
        chk_eq("R3 pc kept", precomp_steps, 2);
        host_write({3'b000, 3'b010, 2'b01});
        chk_eq("R3 last write", rate_code, 1);
        @(negedge clk);
        ccr_wr_en = 1'b1; ccr_rate = 2'b00;
        wr_en = 1'b1; wr_data = {3'b000, 3'b011, 2'b10};
        @(negedge clk);
        ccr_wr_en = 1'b0; wr_en = 1'b0;
        chk_eq("R3 collide rate", rate_code, 0);
        chk_eq("R3 collide pc", precomp_steps, 3);
    endtask

    task automatic t_swreset;
        host_write({3'b100, 3'b100, 2'b11});
        chk_eq("R6 pulse high", sw_rst_pulse, 1);
        chk_eq("R7 rate", rate_code, 3);
        @(negedge clk);
        chk_eq("R6 pulse low", sw_rst_pulse, 0);
        chk_eq("R7 steps", precomp_steps, 4);
        @(negedge clk);
        sw_rst_in = 1'b1;
        @(negedge clk);
        sw_rst_in = 1'b0;
        chk_eq("R7 ext rate", rate_code, 3);
        chk_eq("R7 ext steps", precomp_steps, 4);
        chk_eq("R6 ext no pulse", sw_rst_pulse, 0);
    endtask

    task automatic t_power;
        host_write(8'h40);
        chk_eq("R8 enter", low_power, 1);
        host_write(8'h00);
        chk_eq("R8 hold", low_power, 1);
        @(negedge clk); data_rd = 1'b1;
        @(negedge clk); data_rd = 1'b0;
        chk_eq("R9 data_rd", low_power, 0);
        host_write(8'h40);
        @(negedge clk); status_rd = 1'b1;
        @(negedge clk); status_rd = 1'b0;
        chk_eq("R9 status_rd", low_power, 0);
        host_write(8'h40);
        @(negedge clk); sw_rst_in = 1'b1;
        @(negedge clk); sw_rst_in = 1'b0;
        chk_eq("R9 sw_rst_in", low_power, 0);
        @(negedge clk);
        wr_en = 1'b1; wr_data = 8'h40; data_rd = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; data_rd = 1'b0;
        chk_eq("R9 same cycle", low_power, 0);
        host_write(8'hC0);
        chk_eq("R8 both bits", low_power, 1);
        @(negedge clk);
        chk_eq("R9 own pulse", low_power, 0);
    endtask

    task automatic t_enable;
        host_write({3'b000, 3'b001, 2'b10});
        start_track = 8'd40; track = 8'd39;
        #1 chk_eq("R10 below", precomp_en, 0);
        track = 8'd40;
        #1 chk_eq("R10 at", precomp_en, 1);
        track = 8'd200;
        #1 chk_eq("R10 above", precomp_en, 1);
        host_write({3'b000, 3'b111, 2'b10});
        chk_eq("R10 disabled", precomp_en, 0);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_fields();
        t_default();
        t_ccr();
        t_swreset();
        t_power();
        t_enable();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            finish_run();
        end
    end
endmodule